// File: doc/BRIEF.md
# Third-Order Bitstream Decimator

This block turns a single-bit oversampled stream from a sigma-delta modulator into 16-bit unsigned words. It runs in the modulator clock domain and captures one input bit on every rising edge. Three cascaded accumulators run at the full bit rate. Every 256 clocks a three-stage differencing chain runs once and reduces their result to one output word.

The word uses offset binary coding. The code equals the density of ones times 65536: an all-zeros stream settles to 0, a 50% stream to mid-scale, and a 100% stream is clamped to the top code instead of wrapping. Each new word is announced by a strobe that is high for one clock. After every reset the first three decimated results are withheld while the differencing history fills. A user feeds the stream from reset and reads a word on each strobe.

Top module: `sinc3_decimator`

## Requirements
- R1: While reset is high, the valid strobe is low and the output word is 0.
- R2: After the fill period, the valid strobe rises once every 256 clocks and is high for exactly one clock each time.
- R3: After every reset release, the first three decimation events produce no strobe. The first strobe is seen in the clock after the 1024th rising edge that has reset low.
- R4: An input bit of 1 counts +1 and a bit of 0 counts 0. A settled all-zeros stream gives code 0.
- R5: A settled stream of alternating ones and zeros (50% density) gives code 32768.
- R6: A settled periodic stream gives its ones density times 65536. 13 ones in every 16 bits gives 53248, and 3 ones in every 16 bits gives 12288.
- R7: A settled all-ones stream gives 65535, saturated rather than wrapped to 0.
- R8: The output drops the eight low bits of the 25-bit filter value without saturating below full scale. 255 ones in every 256 bits gives 65280, and one 1 in every 256 bits gives 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock; the data bit is captured on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bitIn | input | 1 | Oversampled single-bit data stream |
| wordOut | output | 16 | Decimated unsigned offset-binary result |
| wordValid | output | 1 | One-clock strobe marking a new result |

## Verification
The bench goes after the two ends of the code range. An all-ones stream would read back as 0 if the clamp were missing. A near-full-scale stream (255 of 256 ones) would read 65535 if the clamp fired too early. A stream with a single 1 in 256 shows whether the dropped low bits are handled correctly. The bench also times the first strobe after each reset: a fill counter that is too short or never re-armed would release an unsettled word early. Strobe spacing and width are measured on every word, which exposes a decimation counter that wraps at the wrong count. The 13/16 and 3/16 patterns exercise asymmetric densities that a wrong integrator chain or comb ordering would distort.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  localparam int ORDER = 3;

  typedef struct packed {
    logic load;
    logic emit;
  } strobe_t;
endpackage

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl
  import sinc3_pkg::*;
#(
  parameter int RATIO = 256
) (
  input  logic    clk,
  input  logic    rst,
  output strobe_t strb
);
  localparam int CW = $clog2(RATIO);
  localparam int FW = $clog2(ORDER + 1);
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
  localparam logic [FW-1:0] FILL = FW'(ORDER);

  logic [CW-1:0] count;
  logic [FW-1:0] fillCnt;
  logic          atLast;

  assign atLast    = (count == LAST);
  assign strb.load = atLast;
  assign strb.emit = atLast && (fillCnt == FILL);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      fillCnt <= '0;
    end else begin
      count <= atLast ? '0 : count + 1'b1;
      if (atLast && fillCnt != FILL) fillCnt <= fillCnt + 1'b1;
    end
  end

  // R2
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (count == LAST) |=> (count == '0));
endmodule

// File: rtl/sinc3_datapath.sv
module sinc3_datapath
  import sinc3_pkg::*;
#(
  parameter int RATIO = 256,
  parameter int OUTW  = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bitIn,
  input  strobe_t         strb,
  output logic [OUTW-1:0] wordOut,
  output logic            validOut
);
  localparam int LOG2R = $clog2(RATIO);
  localparam int ACCW  = 1 + ORDER * LOG2R;
  localparam int SHIFT = ACCW - 1 - OUTW;
  localparam logic [ACCW-1:0] SATLIM = {1'b0, {(ACCW-1){1'b1}}};

  logic [ORDER-1:0][ACCW-1:0] integ;
  logic [ORDER-1:0][ACCW-1:0] addend;
  logic [ORDER-1:0][ACCW-1:0] dly;
  logic [ORDER:0][ACCW-1:0]   cv;
  logic [ACCW-1:0]            combOut;
  logic                       sat;
  logic [OUTW-1:0]            scaled;

  always_comb begin
    addend[0] = {{(ACCW-1){1'b0}}, bitIn};
    for (int k = 1; k < ORDER; k++) addend[k] = integ[k-1];
  end

  always_comb begin
    cv[0] = integ[ORDER-1];
    for (int k = 0; k < ORDER; k++) cv[k+1] = cv[k] - dly[k];
  end

  assign combOut = cv[ORDER];
  assign sat     = combOut > SATLIM;
  assign scaled  = sat ? {OUTW{1'b1}} : combOut[ACCW-2:SHIFT];

  always_ff @(posedge clk) begin
    if (rst) begin
      integ    <= '0;
      dly      <= '0;
      wordOut  <= '0;
      validOut <= 1'b0;
    end else begin
      for (int k = 0; k < ORDER; k++) integ[k] <= integ[k] + addend[k];
      validOut <= strb.emit;
      if (strb.load) begin
        for (int k = 0; k < ORDER; k++) dly[k] <= cv[k];
      end
      if (strb.emit) wordOut <= scaled;
    end
  end

  // R7
  sat_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.emit && combOut[ACCW-1]) |=> (wordOut == {OUTW{1'b1}}));

  // R2
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    validOut |=> !validOut);

  // R3
  valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    validOut |-> $past(strb.load));
endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator
  import sinc3_pkg::*;
#(
  parameter int RATIO = 256,
  parameter int OUTW  = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bitIn,
  output logic [OUTW-1:0] wordOut,
  output logic            wordValid
);
  strobe_t strb;

  sinc3_ctrl #(.RATIO(RATIO)) ctrl_i (
    .clk  (clk),
    .rst  (rst),
    .strb (strb)
  );

  sinc3_datapath #(.RATIO(RATIO), .OUTW(OUTW)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .bitIn    (bitIn),
    .strb     (strb),
    .wordOut  (wordOut),
    .validOut (wordValid)
  );
endmodule

// File: tb/sinc3_decimator_tb_top.sv
module sinc3_decimator_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bitIn = 1'b0;
  logic [15:0] wordOut;
  logic        wordValid;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int lastValid = 0;
  bit seenFirst = 0;
  bit prevValid = 0;
  bit done = 0;
  int tick = 0;

  int    expQ[$];
  string tagQ[$];

  always #5 clk = ~clk;

  sinc3_decimator dut_i (
    .clk       (clk),
    .rst       (rst),
    .bitIn     (bitIn),
    .wordOut   (wordOut),
    .wordValid (wordValid)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic patBit(input int pat, input int n);
    case (pat)
      0: return 1'b0;
      1: return 1'(n % 2 == 0);
      2: return 1'(n % 16 < 13);
      3: return 1'(n % 16 < 3);
      4: return 1'b1;
      5: return 1'(n % 256 != 0);
      default: return 1'(n % 256 == 0);
    endcase
  endfunction

  function automatic int patExp(input int pat);
    case (pat)
      0: return 0;
      1: return 32768;
      2: return 53248;
      3: return 12288;
      4: return 65535;
      5: return 65280;
      default: return 256;
    endcase
  endfunction

  function automatic string patTag(input int pat);
    case (pat)
      0: return "R4";
      1: return "R5";
      2, 3: return "R6";
      4: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Monitor: scoreboard compare, strobe timing
  always @(negedge clk) begin
    if (rst) begin
      seenFirst = 0;
      prevValid = 0;
    end else begin
      if (prevValid) check(!wordValid, "R2 strobe width", int'(wordValid), 0);
      if (wordValid) begin
        if (!seenFirst) begin
          check(cyc == 1024, "R3 first strobe cycle", cyc, 1024);
          seenFirst = 1;
        end else begin
          check(cyc - lastValid == 256, "R2 strobe spacing", cyc - lastValid, 256);
        end
        lastValid = cyc;
        if (expQ.size() == 0) begin
          check(0, "R2 unexpected word", int'(wordOut), -1);
        end else begin
          int e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          if (e >= 0) check(int'(wordOut) == e, t, int'(wordOut), e);
        end
      end
      prevValid = wordValid;
    end
  end

  task automatic runSeg(input int pat, input int blocks);
    for (int b = 0; b < blocks; b++) begin
      tick++;
      if (tick > 3) begin
        expQ.push_back(b >= 3 ? patExp(pat) : -1);
        tagQ.push_back(patTag(pat));
      end
      for (int s = 0; s < 256; s++) begin
        bitIn = patBit(pat, b * 256 + s);
        @(negedge clk);
      end
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      // R1
      check(wordValid == 1'b0, "R1 valid in reset", int'(wordValid), 0);
      check(wordOut == 16'd0, "R1 word in reset", int'(wordOut), 0);
    end
    tick = 0;
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    doReset();
    runSeg(1, 6);
    runSeg(0, 6);
    runSeg(2, 6);
    runSeg(4, 6);
    runSeg(3, 6);
    runSeg(5, 6);
    runSeg(6, 6);
    runSeg(4, 6);
    runSeg(0, 6);
    bitIn = 1'b0;
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R2 words outstanding", expQ.size(), 0);
    // R3: fill suppression re-armed after a mid-run reset
    doReset();
    runSeg(1, 6);
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R3 words outstanding after reset", expQ.size(), 0);
    done = 1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 150000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", n, 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule